// File: doc/BRIEF.md
# Self-timed 1-Wire bus master

This block drives a 1-Wire bus for a host that issues one command at a time. The host presents a command code, a data byte and a few option bits with a one-cycle valid strobe. The master then produces every low pulse, release window and sample point of that command by itself. It drives the bus through an open-drain pull-low enable and reads the bus level through a synchronizer.

The command set has five entries:
- a reset with presence and short detection,
- a single-bit slot that writes a bit and samples the bus,
- a byte write and a byte read, each made of eight chained slots,
- the three-slot search triplet used to walk a ROM identifier tree.

Every phase length is a clock-cycle count. A standard-speed set and an overdrive set of counts are fixed as parameters, and a speed bit captured with each command selects one of them. Results stay on status outputs until the command that next updates them completes. Two host controls complete the block. The first requests a strong pullup to be enabled once a command finishes. The second powers the bus port down.

Top module: `owm_master`

## Requirements
- R1: After reset, `busy`, `ow_pull`, `spu_en`, `line_off` and every result output are 0.
- R2: A strobe with a known code (0 reset, 1 single bit, 2 write byte, 3 read byte, 4 triplet) is accepted only while `busy` is 0 and `pd_req` is 0. `busy` rises on the next cycle, and `ow_pull` is driven only while `busy` is 1. A strobe while `busy` is 1 changes neither the running waveform nor its length.
- R3: A reset holds `ow_pull` high for RSTL cycles, then releases it for RSTL cycles, so `busy` lasts exactly 2*RSTL cycles.
- R4: In the release window, `short_det` is set if the bus is low at cycle SI and `presence` is set if the bus is low at cycle MSP, both counted from release. The bus is read through a two-stage synchronizer.
- R5: A bit slot lasts W0L+REC0 cycles. It drives low for W1L cycles to write 1 and for W0L cycles to write 0. The bus is sampled at cycle MSR of the slot, and a single-bit command (data bit 0 is the bit written) reports the sample on `bit_val`.
- R6: Byte commands run eight back-to-back slots with no idle cycle between them, least significant bit first. A read byte writes all ones and assembles the samples into `rd_data`, with the first sample in bit 0.
- R7: The triplet reads two slots, giving the id bit and its complement. It takes the id bit as the direction when the two differ, and `cmd_dir` when both are 0. When both are 1 it writes 1 and sets `srch_none`. The third slot writes the direction taken, and `srch_id`, `srch_cmp` and `srch_dir` report the result.
- R8: `speed_od`, captured at acceptance, selects the overdrive timing set (1) or the standard set (0) for the whole command.
- R9: `spu_en` rises when a command accepted with `cmd_spu` set completes. It is cleared when the next command is accepted or when `pd_req` is raised.
- R10: `line_off` follows `pd_req` one cycle later. While `line_off` is 1, `ow_pull` is 0, and strobes are ignored while `pd_req` is 1.
- R11: Codes 5 to 7 are ignored: `busy` stays 0 and no result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| cmd_data | input | 8 | Byte to write; bit 0 for a single-bit command |
| cmd_dir | input | 1 | Host direction for the triplet's 0/0 case |
| cmd_spu | input | 1 | Enable strong pullup after this command |
| speed_od | input | 1 | 1 selects overdrive timing |
| pd_req | input | 1 | Power the bus port down |
| ow_in | input | 1 | Bus level, asynchronous |
| ow_pull | output | 1 | Pull-low enable of the open-drain driver |
| busy | output | 1 | Command in progress |
| presence | output | 1 | Presence seen in the last reset |
| short_det | output | 1 | Short seen in the last reset |
| bit_val | output | 1 | Sample of the last single-bit command |
| rd_data | output | 8 | Byte of the last read byte |
| srch_id | output | 1 | Triplet id bit |
| srch_cmp | output | 1 | Triplet complement bit |
| srch_dir | output | 1 | Triplet direction taken |
| srch_none | output | 1 | Triplet found both bits 1 |
| spu_en | output | 1 | Strong pullup enable |
| line_off | output | 1 | Bus port powered down |

## Verification
The hardest case to reach from the ports is a presence pulse seen without a short. It needs the bus high at the short sample and low at the presence sample, with both points taken through the synchronizer delay. The bench's slave model counts cycles from the falling edge of `ow_pull` and pulls the bus low only inside a window between those two points. A second mode holds the bus low throughout, which gives the short case. Triplet corner cases, including both bits 1 and the host-chosen 0/0 branch, come from a queue of bits that the slave returns one per slot.

// File: rtl/owm_pkg.sv
package owm_pkg;
   typedef enum logic [2:0] {
      OP_RST   = 3'd0,
      OP_BIT   = 3'd1,
      OP_WBYTE = 3'd2,
      OP_RBYTE = 3'd3,
      OP_TRIP  = 3'd4
   } op_e;

   typedef enum logic [1:0] {PH_IDLE, PH_RLOW, PH_RHIGH, PH_SLOT} ph_e;

   function automatic logic op_known(input logic [2:0] c);
      return c <= 3'd4;
   endfunction

   // index of the final slot of a command
   function automatic logic [2:0] last_idx(input logic [2:0] c);
      case (c)
         OP_WBYTE, OP_RBYTE: return 3'd7;
         OP_TRIP:            return 3'd2;
         default:            return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/owm_tsel.sv
module owm_tsel #(
   parameter int CW       = 16,
   parameter int STD_RSTL = 24000,
   parameter int STD_SI   = 400,
   parameter int STD_MSP  = 3500,
   parameter int STD_W1L  = 400,
   parameter int STD_MSR  = 600,
   parameter int STD_W0L  = 3000,
   parameter int STD_REC0 = 250,
   parameter int OD_RSTL  = 2400,
   parameter int OD_SI    = 50,
   parameter int OD_MSP   = 425,
   parameter int OD_W1L   = 50,
   parameter int OD_MSR   = 75,
   parameter int OD_W0L   = 375,
   parameter int OD_REC0  = 125
) (
   input  logic          spd_od,
   output logic [CW-1:0] t_rstl,
   output logic [CW-1:0] t_si,
   output logic [CW-1:0] t_msp,
   output logic [CW-1:0] t_w1l,
   output logic [CW-1:0] t_msr,
   output logic [CW-1:0] t_w0l,
   output logic [CW-1:0] t_slot
);
   localparam int STD_SLOT = STD_W0L + STD_REC0;
   localparam int OD_SLOT  = OD_W0L + OD_REC0;

   assign t_rstl = spd_od ? CW'(OD_RSTL) : CW'(STD_RSTL);
   assign t_si   = spd_od ? CW'(OD_SI)   : CW'(STD_SI);
   assign t_msp  = spd_od ? CW'(OD_MSP)  : CW'(STD_MSP);
   assign t_w1l  = spd_od ? CW'(OD_W1L)  : CW'(STD_W1L);
   assign t_msr  = spd_od ? CW'(OD_MSR)  : CW'(STD_MSR);
   assign t_w0l  = spd_od ? CW'(OD_W0L)  : CW'(STD_W0L);
   assign t_slot = spd_od ? CW'(OD_SLOT) : CW'(STD_SLOT);
endmodule

// File: rtl/owm_engine.sv
module owm_engine
   import owm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_rst,
   input  logic          wbit,
   input  logic          line,
   input  logic [CW-1:0] t_rstl,
   input  logic [CW-1:0] t_si,
   input  logic [CW-1:0] t_msp,
   input  logic [CW-1:0] t_w1l,
   input  logic [CW-1:0] t_msr,
   input  logic [CW-1:0] t_w0l,
   input  logic [CW-1:0] t_slot,
   output logic          pull,
   output logic          done,
   output logic          samp,
   output logic          pres,
   output logic          shrt
);
   ph_e           ph;
   logic [CW-1:0] cnt;
   logic          wbit_q;
   logic          rlow_end;

   assign rlow_end = (ph == PH_RLOW) && (cnt == t_rstl - 1'b1);
   assign done = ((ph == PH_RHIGH) && (cnt == t_rstl - 1'b1)) ||
                 ((ph == PH_SLOT)  && (cnt == t_slot - 1'b1));
   assign pull = (ph == PH_RLOW) ||
                 ((ph == PH_SLOT) && (cnt < (wbit_q ? t_w1l : t_w0l)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         wbit_q <= 1'b1;
         samp   <= 1'b0;
         pres   <= 1'b0;
         shrt   <= 1'b0;
      end else if (start) begin
         ph     <= is_rst ? PH_RLOW : PH_SLOT;
         cnt    <= '0;
         wbit_q <= wbit;
         if (is_rst) begin
            pres <= 1'b0;
            shrt <= 1'b0;
         end
      end else begin
         case (ph)
            PH_RLOW: begin
               if (rlow_end) begin
                  ph  <= PH_RHIGH;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_RHIGH: begin
               if (cnt == t_si)  shrt <= ~line;
               if (cnt == t_msp) pres <= ~line;
               if (done) ph  <= PH_IDLE;
               else      cnt <= cnt + 1'b1;
            end
            PH_SLOT: begin
               if (cnt == t_msr) samp <= line;
               if (done) ph  <= PH_IDLE;
               else      cnt <= cnt + 1'b1;
            end
            default: cnt <= '0;
         endcase
      end
   end
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
   import owm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic [7:0] cmd_data,
   input  logic       cmd_dir,
   input  logic       cmd_spu,
   input  logic       speed_od,
   input  logic       pd_req,
   input  logic       eng_done,
   input  logic       eng_bit,
   input  logic       eng_pres,
   input  logic       eng_shrt,
   output logic       start,
   output logic       is_rst,
   output logic       wbit,
   output logic       spd_q,
   output logic       busy,
   output logic       presence,
   output logic       short_det,
   output logic       bit_val,
   output logic [7:0] rd_data,
   output logic       srch_id,
   output logic       srch_cmp,
   output logic       srch_dir,
   output logic       srch_none,
   output logic       spu_en
);
   logic       accept, fin;
   logic [2:0] op_q, idx;
   logic [7:0] dat_q;
   logic [6:0] shreg;
   logic       dir_q, spu_q, id_q, cmp_q, dsel_q, tdir;

   assign accept = cmd_valid && !busy && !pd_req && op_known(cmd_code);
   assign fin    = busy && eng_done && (idx == last_idx(op_q));
   assign start  = accept || (busy && eng_done && !fin);
   assign is_rst = accept && (cmd_code == OP_RST);
   // id bit wins when the pair differs; 0/0 takes the host bit; 1/1 writes 1
   assign tdir   = (id_q != eng_bit) ? id_q : (id_q | dir_q);

   always_comb begin
      if (accept) begin
         case (cmd_code)
            OP_BIT, OP_WBYTE: wbit = cmd_data[0];
            default:          wbit = 1'b1;
         endcase
      end else begin
         case (op_q)
            OP_WBYTE: wbit = dat_q[idx + 3'd1];
            OP_TRIP:  wbit = (idx == 3'd1) ? tdir : 1'b1;
            default:  wbit = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; op_q <= '0; idx <= '0; dat_q <= '0; shreg <= '0;
         dir_q <= 1'b0; spu_q <= 1'b0; spd_q <= 1'b0;
         id_q <= 1'b0; cmp_q <= 1'b0; dsel_q <= 1'b0;
         presence <= 1'b0; short_det <= 1'b0; bit_val <= 1'b0; rd_data <= '0;
         srch_id <= 1'b0; srch_cmp <= 1'b0; srch_dir <= 1'b0; srch_none <= 1'b0;
         spu_en <= 1'b0;
      end else begin
         if (accept) begin
            busy   <= 1'b1;
            op_q   <= cmd_code;
            dat_q  <= cmd_data;
            dir_q  <= cmd_dir;
            spu_q  <= cmd_spu;
            spd_q  <= speed_od;
            idx    <= '0;
            spu_en <= 1'b0;
         end else if (busy && eng_done) begin
            shreg <= {eng_bit, shreg[6:1]};
            if (idx == 3'd0) id_q <= eng_bit;
            if (idx == 3'd1) begin
               cmp_q  <= eng_bit;
               dsel_q <= tdir;
            end
            if (fin) begin
               busy   <= 1'b0;
               spu_en <= spu_q;
               case (op_q)
                  OP_RST: begin
                     presence  <= eng_pres;
                     short_det <= eng_shrt;
                  end
                  OP_BIT:   bit_val <= eng_bit;
                  OP_RBYTE: rd_data <= {eng_bit, shreg};
                  OP_TRIP: begin
                     srch_id   <= id_q;
                     srch_cmp  <= cmp_q;
                     srch_dir  <= dsel_q;
                     srch_none <= id_q & cmp_q;
                  end
                  default: ;
               endcase
            end else begin
               idx <= idx + 3'd1;
            end
         end
         if (pd_req) spu_en <= 1'b0;
      end
   end
endmodule

// File: rtl/owm_master.sv
module owm_master #(
   parameter int SYNC_STAGES = 2,
   parameter int STD_RSTL = 24000,
   parameter int STD_SI   = 400,
   parameter int STD_MSP  = 3500,
   parameter int STD_W1L  = 400,
   parameter int STD_MSR  = 600,
   parameter int STD_W0L  = 3000,
   parameter int STD_REC0 = 250,
   parameter int OD_RSTL  = 2400,
   parameter int OD_SI    = 50,
   parameter int OD_MSP   = 425,
   parameter int OD_W1L   = 50,
   parameter int OD_MSR   = 75,
   parameter int OD_W0L   = 375,
   parameter int OD_REC0  = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic [7:0] cmd_data,
   input  logic       cmd_dir,
   input  logic       cmd_spu,
   input  logic       speed_od,
   input  logic       pd_req,
   input  logic       ow_in,
   output logic       ow_pull,
   output logic       busy,
   output logic       presence,
   output logic       short_det,
   output logic       bit_val,
   output logic [7:0] rd_data,
   output logic       srch_id,
   output logic       srch_cmp,
   output logic       srch_dir,
   output logic       srch_none,
   output logic       spu_en,
   output logic       line_off
);
   localparam int STD_MAX = (STD_RSTL > STD_W0L + STD_REC0) ? STD_RSTL : STD_W0L + STD_REC0;
   localparam int OD_MAX  = (OD_RSTL > OD_W0L + OD_REC0) ? OD_RSTL : OD_W0L + OD_REC0;
   localparam int T_MAX   = (STD_MAX > OD_MAX) ? STD_MAX : OD_MAX;
   localparam int CW      = $clog2(T_MAX + 1);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (!(STD_W1L < STD_MSR && STD_MSR < STD_W0L + STD_REC0 && STD_W1L < STD_W0L &&
            STD_SI < STD_MSP && STD_MSP < STD_RSTL)) begin : g_bad_std
         $error("standard timing set out of order");
      end
      if (!(OD_W1L < OD_MSR && OD_MSR < OD_W0L + OD_REC0 && OD_W1L < OD_W0L &&
            OD_SI < OD_MSP && OD_MSP < OD_RSTL)) begin : g_bad_od
         $error("overdrive timing set out of order");
      end
   endgenerate

   logic          line_s, spd_q, start, is_rst, wbit;
   logic          eng_pull, eng_done, eng_bit, eng_pres, eng_shrt;
   logic [CW-1:0] t_rstl, t_si, t_msp, t_w1l, t_msr, t_w0l, t_slot;

   owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ow_in), .q(line_s));

   owm_tsel #(
      .CW(CW),
      .STD_RSTL(STD_RSTL), .STD_SI(STD_SI), .STD_MSP(STD_MSP), .STD_W1L(STD_W1L),
      .STD_MSR(STD_MSR), .STD_W0L(STD_W0L), .STD_REC0(STD_REC0),
      .OD_RSTL(OD_RSTL), .OD_SI(OD_SI), .OD_MSP(OD_MSP), .OD_W1L(OD_W1L),
      .OD_MSR(OD_MSR), .OD_W0L(OD_W0L), .OD_REC0(OD_REC0)
   ) u_tsel (
      .spd_od(spd_q), .t_rstl(t_rstl), .t_si(t_si), .t_msp(t_msp), .t_w1l(t_w1l),
      .t_msr(t_msr), .t_w0l(t_w0l), .t_slot(t_slot));

   owm_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_data(cmd_data), .cmd_dir(cmd_dir), .cmd_spu(cmd_spu), .speed_od(speed_od),
      .pd_req(pd_req), .eng_done(eng_done), .eng_bit(eng_bit), .eng_pres(eng_pres),
      .eng_shrt(eng_shrt), .start(start), .is_rst(is_rst), .wbit(wbit), .spd_q(spd_q),
      .busy(busy), .presence(presence), .short_det(short_det), .bit_val(bit_val),
      .rd_data(rd_data), .srch_id(srch_id), .srch_cmp(srch_cmp), .srch_dir(srch_dir),
      .srch_none(srch_none), .spu_en(spu_en));

   owm_engine #(.CW(CW)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .is_rst(is_rst), .wbit(wbit),
      .line(line_s), .t_rstl(t_rstl), .t_si(t_si), .t_msp(t_msp), .t_w1l(t_w1l),
      .t_msr(t_msr), .t_w0l(t_w0l), .t_slot(t_slot), .pull(eng_pull),
      .done(eng_done), .samp(eng_bit), .pres(eng_pres), .shrt(eng_shrt));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) line_off <= 1'b0;
      else        line_off <= pd_req;

   assign ow_pull = eng_pull & ~line_off;
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_code,
   input logic       pd_req,
   input logic       ow_pull,
   input logic       busy,
   input logic       srch_id,
   input logic       srch_cmp,
   input logic       srch_dir,
   input logic       srch_none,
   input logic       spu_en,
   input logic       line_off
);
   // R2
   take_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !pd_req && cmd_code <= 3'd4) |=> busy);
   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ow_pull);
   // R11
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_code > 3'd4) |=> !busy);
   // R9
   spu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spu_en |-> !busy);
   // R10
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_off |-> !ow_pull);
   // R7
   trip_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_id != srch_cmp) |-> (srch_dir == srch_id));
   // R7
   trip_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srch_none |-> (srch_id && srch_cmp && srch_dir));
endmodule

bind owm_master owm_master_chk u_chk (.*);

// File: tb/owm_master_tb.sv
module owm_master_tb;
   localparam int S_RSTL = 40, S_SI = 4, S_MSP = 20, S_W1L = 3, S_MSR = 8, S_W0L = 16, S_REC0 = 4;
   localparam int O_RSTL = 16, O_SI = 2, O_MSP = 8, O_W1L = 1, O_MSR = 4, O_W0L = 6, O_REC0 = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0, cmd_valid = 1'b0, cmd_dir = 1'b0, cmd_spu = 1'b0;
   logic       speed_od = 1'b0, pd_req = 1'b0, slave_low = 1'b0;
   logic [2:0] cmd_code = '0;
   logic [7:0] cmd_data = '0;
   logic       ow_in, ow_pull, busy, presence, short_det, bit_val;
   logic       srch_id, srch_cmp, srch_dir, srch_none, spu_en, line_off;
   logic [7:0] rd_data;

   assign ow_in = ~(ow_pull | slave_low);

   owm_master #(
      .STD_RSTL(S_RSTL), .STD_SI(S_SI), .STD_MSP(S_MSP), .STD_W1L(S_W1L),
      .STD_MSR(S_MSR), .STD_W0L(S_W0L), .STD_REC0(S_REC0),
      .OD_RSTL(O_RSTL), .OD_SI(O_SI), .OD_MSP(O_MSP), .OD_W1L(O_W1L),
      .OD_MSR(O_MSR), .OD_W0L(O_W0L), .OD_REC0(O_REC0)
   ) u_dut (.*);

   int total = 0, bad = 0;
   bit    expq[$];
   string tagq[$];
   bit    bitq[$];
   bit    mon_on = 0, prev_pull = 0, s_od = 0;
   int    smode = 0, rel = 0;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   function automatic void push_n(bit v, int n, string t);
      for (int i = 0; i < n; i++) begin expq.push_back(v); tagq.push_back(t); end
   endfunction

   function automatic void push_rst(bit od, string t);
      int l = od ? O_RSTL : S_RSTL;
      push_n(1'b1, l, t); push_n(1'b0, l, t);
   endfunction

   function automatic void push_slot(bit wb, bit od, string t);
      int low  = wb ? (od ? O_W1L : S_W1L) : (od ? O_W0L : S_W0L);
      int slot = od ? O_W0L + O_REC0 : S_W0L + S_REC0;
      push_n(1'b1, low, t); push_n(1'b0, slot - low, t);
   endfunction

   // per-cycle reference comparison of busy and the pull-low enable
   always @(posedge clk) begin
      bit ep; string t;
      #5;
      if (mon_on) begin
         if (expq.size() > 0) begin
            ep = expq.pop_front(); t = tagq.pop_front(); chk({t, " busy"}, busy, 1);
         end else begin
            ep = 0; t = "R2 idle"; chk({t, " busy"}, busy, 0);
         end
         chk({t, " pull"}, ow_pull, ep);
      end
   end

   // slave model: 1 presence window, 2 stuck low, 3 one queued bit per slot
   always @(negedge clk) begin
      if (prev_pull && !ow_pull) rel = 0; else rel++;
      case (smode)
         1: slave_low = busy && !ow_pull && rel >= (s_od ? O_SI : S_SI) + 1 &&
                        rel <= (s_od ? O_MSP : S_MSP);
         2: slave_low = 1'b1;
         3: if (!prev_pull && ow_pull) slave_low = (bitq.size() > 0) ? !bitq.pop_front() : 1'b0;
         default: slave_low = 1'b0;
      endcase
      prev_pull = ow_pull;
   end

   task automatic strobe(logic [2:0] c, logic [7:0] d, bit dir, bit spu, bit od);
      @(negedge clk);
      cmd_code = c; cmd_data = d; cmd_dir = dir; cmd_spu = spu; speed_od = od; cmd_valid = 1'b1;
   endtask

   task automatic drop();
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      smode = 0;
   endtask

   task automatic do_rst(bit od, int mode, string t);
      s_od = od; smode = mode;
      strobe(3'd0, 8'h00, 0, 0, od); push_rst(od, t); drop(); wait_idle();
   endtask

   task automatic do_trip(bit id, bit cmp, bit dir);
      bit d = (id != cmp) ? id : (id | dir);
      bitq.push_back(id); bitq.push_back(cmp); bitq.push_back(1'b1); smode = 3;
      strobe(3'd4, 8'h00, dir, 0, 0);
      push_slot(1, 0, "R7"); push_slot(1, 0, "R7"); push_slot(d, 0, "R7");
      drop(); wait_idle();
      chk("R7 srch_id", srch_id, id); chk("R7 srch_cmp", srch_cmp, cmp);
      chk("R7 srch_dir", srch_dir, d); chk("R7 srch_none", srch_none, id & cmp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1;
      // R1 reset state
      chk("R1 busy", busy, 0); chk("R1 pull", ow_pull, 0); chk("R1 presence", presence, 0);
      chk("R1 short", short_det, 0); chk("R1 rd_data", rd_data, 0);
      chk("R1 spu_en", spu_en, 0); chk("R1 line_off", line_off, 0);

      // R3 and R4: reset with a presence pulse, standard speed
      do_rst(0, 1, "R3");
      chk("R4 presence", presence, 1); chk("R4 short", short_det, 0);
      // R8: overdrive reset, empty bus
      do_rst(1, 0, "R8");
      chk("R4 no presence", presence, 0); chk("R4 no short", short_det, 0);
      // R4: bus held low
      do_rst(0, 2, "R4");
      chk("R4 short seen", short_det, 1); chk("R4 presence on short", presence, 1);

      // R6: write byte, LSB first
      strobe(3'd2, 8'hA5, 0, 0, 0);
      for (int i = 0; i < 8; i++) push_slot(8'hA5 >> i, 0, "R6");
      drop(); wait_idle();

      // R6 and R8: read byte at overdrive
      for (int i = 0; i < 8; i++) bitq.push_back((8'h3C >> i) & 1);
      smode = 3;
      strobe(3'd3, 8'h00, 0, 0, 1);
      for (int i = 0; i < 8; i++) push_slot(1, 1, "R6");
      drop(); wait_idle();
      chk("R6 rd_data", rd_data, 8'h3C);

      // R5: single bits
      bitq.push_back(0); smode = 3;
      strobe(3'd1, 8'h01, 0, 0, 0); push_slot(1, 0, "R5"); drop(); wait_idle();
      chk("R5 read 0", bit_val, 0);
      bitq.push_back(1); smode = 3;
      strobe(3'd1, 8'h01, 0, 0, 0); push_slot(1, 0, "R5"); drop(); wait_idle();
      chk("R5 read 1", bit_val, 1);
      strobe(3'd1, 8'h00, 0, 0, 0); push_slot(0, 0, "R5"); drop(); wait_idle();
      chk("R5 write 0 samples low", bit_val, 0);

      // R7: triplet cases
      do_trip(0, 1, 1);
      do_trip(1, 0, 0);
      do_trip(0, 0, 1);
      do_trip(0, 0, 0);
      do_trip(1, 1, 0);

      // R2: strobe while busy is ignored
      s_od = 0; smode = 0;
      strobe(3'd0, 8'h00, 0, 0, 0); push_rst(0, "R2"); drop();
      repeat (5) @(negedge clk);
      cmd_code = 3'd2; cmd_data = 8'h00; cmd_valid = 1'b1;
      drop(); wait_idle();
      chk("R2 idle after ignored strobe", busy, 0);

      // R11: unknown code
      strobe(3'd6, 8'hFF, 0, 0, 0); drop();
      repeat (3) @(negedge clk);
      chk("R11 busy", busy, 0); chk("R11 rd_data", rd_data, 8'h3C);

      // R9: strong pullup after completion, cleared by next accept
      strobe(3'd1, 8'h01, 0, 1, 1); push_slot(1, 1, "R9"); drop();
      chk("R9 off while busy", spu_en, 0);
      wait_idle();
      chk("R9 on after done", spu_en, 1);
      strobe(3'd1, 8'h01, 0, 0, 1); push_slot(1, 1, "R9"); drop();
      chk("R9 cleared on accept", spu_en, 0);
      wait_idle();
      strobe(3'd1, 8'h01, 0, 1, 1); push_slot(1, 1, "R9"); drop(); wait_idle();

      // R10: power-down
      @(negedge clk); pd_req = 1'b1;
      @(negedge clk);
      chk("R10 line_off", line_off, 1); chk("R10 spu cleared", spu_en, 0);
      strobe(3'd0, 8'h00, 0, 0, 0); drop();
      chk("R10 ignored", busy, 0);
      @(negedge clk); pd_req = 1'b0;
      @(negedge clk);
      chk("R10 line back", line_off, 0);
      repeat (4) @(negedge clk);
      report();
   end
endmodule